// File: doc/BRIEF.md
# Two-Bank Register File with Split Flag Word

The block holds the general registers of a small 16-bit processor. The registers are arranged as two banks of sixteen 16-bit words. Only one bank is visible at a time. The visible bank is chosen by a bank-select bit kept inside the file's own flag word, so switching banks takes only an ordinary register write and no separate command from the sequencer.

The topmost register of each bank is the flag word. Its upper byte is one physical register shared by both banks, and it holds the bank-select bit. Its lower byte is separate for each bank and holds the ALU condition flags. A narrow update port lets the ALU refresh those flags after a compare without going through the write port.

Each read is steered to either the ALU-side output or the bus-side output. Each write takes its data from either the ALU-side input or the bus-side input. Storage is a plain synchronous memory that can map onto block RAM. Reads return data two clock edges after they are issued.

Top module: `dual_bank_regfile`

## Requirements
- R1: There are two banks of sixteen 16-bit registers. A write to register n in one bank leaves register n in the other bank unchanged.
- R2: A read issued with `rd_en` high at a rising edge sets the output flag for the chosen side one edge later and places the data there: `rd_to_bus`=0 selects the ALU side, 1 selects the bus side. The other side's valid flag stays low and its data holds its last value.
- R3: A write with `wr_en` high stores `alu_wdata` when `wr_from_bus`=0 and `bus_wdata` when `wr_from_bus`=1. With `wr_en` low, nothing is stored.
- R4: `bank_sel` equals bit 15 of the flag word (0 = bank zero, 1 = bank one). A flag write that changes that bit affects accesses from the next cycle onward. A read issued in the same cycle as that write still uses the old bank.
- R5: The flag word is address 15. Bits 15:8 are shared by both banks. Bits 7:0 are kept per bank. A write to address 15 loads the upper byte and the lower byte of the active bank.
- R6: With `flag_upd_en` high, `flag_upd_data` is loaded into bits 7:0 of the active bank's flag word. When it coincides with a write to address 15, the update port wins the lower byte and the write still loads the upper byte.
- R7: Reset (`rst` high at a rising edge, synchronous) clears both flag words, `bank_sel`, both valid flags and both read data outputs.
- R8: A read and a write to the same address in the same cycle return the value held before the write.
- R9: With `rd_en` low, neither valid flag rises and both read data outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Issue a read this cycle |
| rd_to_bus | input | 1 | Read destination: 0 ALU side, 1 bus side |
| rd_addr | input | 4 | Register index to read |
| wr_en | input | 1 | Perform a write this cycle |
| wr_from_bus | input | 1 | Write source: 0 ALU side, 1 bus side |
| wr_addr | input | 4 | Register index to write |
| alu_wdata | input | 16 | Write data from the ALU side |
| bus_wdata | input | 16 | Write data from the bus side |
| flag_upd_en | input | 1 | Load condition flags of the active bank |
| flag_upd_data | input | 8 | Condition flag value |
| alu_rdata | output | 16 | Read data toward the ALU |
| alu_rvalid | output | 1 | ALU-side read data valid |
| bus_rdata | output | 16 | Read data toward the bus |
| bus_rvalid | output | 1 | Bus-side read data valid |
| bank_sel | output | 1 | Active bank |

## Verification
The assertions assume that reset is held for at least two clock edges with `rd_en` low. Under that assumption, the two-edge look-back of the read pipeline never reaches values from before the first edge. They also assume that control inputs are known at every edge.

The stimulus drives all inputs on the falling edge. It keeps every control input at zero during and right after reset. It only reads registers it has already written, so no check depends on the power-up content of the memory.

// File: rtl/regf_pkg.sv
package regf_pkg;

  typedef enum logic {
    SIDE_ALU = 1'b0,
    SIDE_BUS = 1'b1
  } side_e;

  typedef struct packed {
    logic  valid;
    side_e side;
    logic  is_flag;
  } rd_ctl_t;

endpackage

// File: rtl/regf_mem.sv
module regf_mem #(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 16,
  localparam int DEPTH  = 2 * REG_CNT,
  localparam int MAW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MAW-1:0]    waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MAW-1:0]    raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  // Simple dual-port, read-before-write; no reset so block RAM fits.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

endmodule

// File: rtl/regf_flags.sv
module regf_flags #(
  parameter int DATA_W = 16,
  parameter int RB_BIT = 15,
  localparam int HALF  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              upd_en,
  input  logic [HALF-1:0]   upd_data,
  output logic [DATA_W-1:0] flag_word,
  output logic              bank
);

  logic [DATA_W-HALF-1:0] shared_q;
  logic [HALF-1:0]        low_q [2];

  always_ff @(posedge clk) begin
    if (rst)        shared_q <= '0;
    else if (wr_en) shared_q <= wdata[DATA_W-1:HALF];
  end

  assign bank = shared_q[RB_BIT-HALF];

  for (genvar b = 0; b < 2; b++) begin : g_bank_low
    logic active;
    assign active = (bank == b[0]);
    always_ff @(posedge clk) begin
      if (rst)                  low_q[b] <= '0;
      else if (active && upd_en) low_q[b] <= upd_data;
      else if (active && wr_en)  low_q[b] <= wdata[HALF-1:0];
    end
  end

  assign flag_word = {shared_q, low_q[bank]};

endmodule

// File: rtl/regf_route.sv
module regf_route
  import regf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_ctl_t           ctl,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] alu_rdata,
  output logic              alu_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);

  logic to_alu, to_bus;
  assign to_alu = ctl.valid && (ctl.side == SIDE_ALU);
  assign to_bus = ctl.valid && (ctl.side == SIDE_BUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      alu_rdata  <= '0;
      bus_rdata  <= '0;
      alu_rvalid <= 1'b0;
      bus_rvalid <= 1'b0;
    end else begin
      alu_rvalid <= to_alu;
      bus_rvalid <= to_bus;
      if (to_alu) alu_rdata <= data;
      if (to_bus) bus_rdata <= data;
    end
  end

endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
  import regf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 16,
  parameter int RB_BIT  = 15,
  localparam int AW     = $clog2(REG_CNT),
  localparam int HALF   = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_to_bus,
  input  logic [AW-1:0]     rd_addr,
  input  logic              wr_en,
  input  logic              wr_from_bus,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] alu_wdata,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              flag_upd_en,
  input  logic [HALF-1:0]   flag_upd_data,
  output logic [DATA_W-1:0] alu_rdata,
  output logic              alu_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              bank_sel
);

  localparam logic [AW-1:0] FLAG_ADDR = AW'(REG_CNT - 1);

  logic [DATA_W-1:0] wdata;
  logic              wr_flag, wr_mem;
  logic [DATA_W-1:0] flag_word, flag_snap_q, mem_rdata, sel_data;
  logic              bank;
  rd_ctl_t           ctl_q;

  assign wdata   = wr_from_bus ? bus_wdata : alu_wdata;
  assign wr_flag = wr_en && (wr_addr == FLAG_ADDR);
  assign wr_mem  = wr_en && (wr_addr != FLAG_ADDR);

  regf_flags #(.DATA_W(DATA_W), .RB_BIT(RB_BIT)) u_flags (
    .clk(clk), .rst(rst), .wr_en(wr_flag), .wdata(wdata),
    .upd_en(flag_upd_en), .upd_data(flag_upd_data),
    .flag_word(flag_word), .bank(bank)
  );

  regf_mem #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_mem (
    .clk(clk), .we(wr_mem),
    .waddr({bank, wr_addr}), .wdata(wdata),
    .raddr({bank, rd_addr}), .rdata(mem_rdata)
  );

  // Stage 1: control and flag snapshot aligned with the memory read.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q       <= '{valid: 1'b0, side: SIDE_ALU, is_flag: 1'b0};
      flag_snap_q <= '0;
    end else begin
      ctl_q.valid   <= rd_en;
      ctl_q.side    <= rd_to_bus ? SIDE_BUS : SIDE_ALU;
      ctl_q.is_flag <= (rd_addr == FLAG_ADDR);
      flag_snap_q   <= flag_word;
    end
  end

  assign sel_data = ctl_q.is_flag ? flag_snap_q : mem_rdata;

  // Stage 2: registered steering to either side.
  regf_route #(.DATA_W(DATA_W)) u_route (
    .clk(clk), .rst(rst), .ctl(ctl_q), .data(sel_data),
    .alu_rdata(alu_rdata), .alu_rvalid(alu_rvalid),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  assign bank_sel = bank;

endmodule

// File: rtl/regf_chk.sv
module regf_chk #(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 16,
  localparam int AW     = $clog2(REG_CNT)
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              rd_to_bus,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DATA_W-1:0] alu_rdata,
  input logic              alu_rvalid,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              bank_sel
);

  localparam logic [AW-1:0] FLAG_ADDR = AW'(REG_CNT - 1);

  // R2
  alu_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    alu_rvalid |-> ($past(rd_en, 2) && !$past(rd_to_bus, 2)));

  // R2
  bus_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> ($past(rd_en, 2) && $past(rd_to_bus, 2)));

  // R2
  one_side_chk: assert property (@(posedge clk) disable iff (rst)
    !(alu_rvalid && bus_rvalid));

  // R9
  alu_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !alu_rvalid |-> $stable(alu_rdata));

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> $stable(bus_rdata));

  // R4
  bank_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(bank_sel) |-> $past(wr_en && (wr_addr == FLAG_ADDR)));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!alu_rvalid && !bus_rvalid && !bank_sel
             && alu_rdata == '0 && bus_rdata == '0));

endmodule

bind dual_bank_regfile regf_chk #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_to_bus(rd_to_bus),
  .wr_en(wr_en), .wr_addr(wr_addr),
  .alu_rdata(alu_rdata), .alu_rvalid(alu_rvalid),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bank_sel(bank_sel)
);

// File: tb/dual_bank_regfile_tb.sv
module dual_bank_regfile_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        rd_en, rd_to_bus, wr_en, wr_from_bus, flag_upd_en;
  logic [3:0]  rd_addr, wr_addr;
  logic [15:0] alu_wdata, bus_wdata;
  logic [7:0]  flag_upd_data;
  logic [15:0] alu_rdata, bus_rdata;
  logic        alu_rvalid, bus_rvalid, bank_sel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_bank_regfile u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_to_bus(rd_to_bus), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_from_bus(wr_from_bus), .wr_addr(wr_addr),
    .alu_wdata(alu_wdata), .bus_wdata(bus_wdata),
    .flag_upd_en(flag_upd_en), .flag_upd_data(flag_upd_data),
    .alu_rdata(alu_rdata), .alu_rvalid(alu_rvalid),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bank_sel(bank_sel)
  );

  // Vector: [21] write, [20] bus side, [19:16] addr, [15:0] data or expected.
  localparam logic [21:0] VEC [10] = '{
    {1'b1, 1'b0, 4'd0,  16'h1234},
    {1'b1, 1'b1, 4'd3,  16'hABCD},
    {1'b1, 1'b0, 4'd14, 16'h0F0F},
    {1'b1, 1'b1, 4'd7,  16'h8001},
    {1'b1, 1'b1, 4'd1,  16'hFFFF},
    {1'b0, 1'b1, 4'd0,  16'h1234},
    {1'b0, 1'b0, 4'd3,  16'hABCD},
    {1'b0, 1'b0, 4'd14, 16'h0F0F},
    {1'b0, 1'b1, 4'd7,  16'h8001},
    {1'b0, 1'b0, 4'd1,  16'hFFFF}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_en = 0; rd_to_bus = 0; rd_addr = 0; wr_en = 0; wr_from_bus = 0;
    wr_addr = 0; alu_wdata = 0; bus_wdata = 0; flag_upd_en = 0; flag_upd_data = 0;
  endtask

  // Drive one write; the other source carries the inverted value (R3).
  task automatic do_write(input logic bus, input logic [3:0] a, input logic [15:0] d);
    wr_en = 1; wr_from_bus = bus; wr_addr = a;
    alu_wdata = bus ? ~d : d;
    bus_wdata = bus ? d : ~d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_read(input string req, input logic bus, input logic [3:0] a,
                         input logic [15:0] exp);
    rd_en = 1; rd_to_bus = bus; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
    check(req, bus ? bus_rdata : alu_rdata, exp);
    check({req, " other side idle"}, {15'd0, bus ? alu_rvalid : bus_rvalid}, 16'd0);
    check({req, " valid"}, {15'd0, bus ? bus_rvalid : alu_rvalid}, 16'd1);
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    // R7: reset state at the ports
    check("R7 alu_rdata", alu_rdata, 16'h0);
    check("R7 bus_rdata", bus_rdata, 16'h0);
    check("R7 valids", {14'd0, alu_rvalid, bus_rvalid}, 16'h0);
    check("R7 bank_sel", {15'd0, bank_sel}, 16'h0);
    rst = 0;
    @(negedge clk);
    do_read("R7 flag word after reset", 1'b1, 4'd15, 16'h0000);

    // R1 R2 R3: vector table in bank zero
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][21]) do_write(VEC[i][20], VEC[i][19:16], VEC[i][15:0]);
      else do_read("R2 R3 table read", VEC[i][20], VEC[i][19:16], VEC[i][15:0]);
    end

    // R5 R4: switch to bank one by writing the flag word
    do_write(1'b1, 4'd15, 16'h8055);
    check("R4 bank_sel after flag write", {15'd0, bank_sel}, 16'h1);
    do_read("R5 bank one flag word", 1'b0, 4'd15, 16'h8000);
    do_write(1'b0, 4'd0, 16'h5A5A);
    do_read("R1 bank one R0", 1'b1, 4'd0, 16'h5A5A);
    do_write(1'b1, 4'd15, 16'h0000);
    check("R4 bank_sel back to zero", {15'd0, bank_sel}, 16'h0);
    do_read("R1 bank zero R0 kept", 1'b0, 4'd0, 16'h1234);
    do_read("R5 bank zero low byte kept", 1'b1, 4'd15, 16'h0055);

    // R6: flag update port, then collision with a flag write
    flag_upd_en = 1; flag_upd_data = 8'h3C;
    @(negedge clk);
    flag_upd_en = 0;
    do_read("R6 update port", 1'b0, 4'd15, 16'h003C);
    flag_upd_en = 1; flag_upd_data = 8'h77;
    do_write(1'b1, 4'd15, 16'h81AA);
    flag_upd_en = 0;
    do_read("R6 collision upper byte", 1'b1, 4'd15, 16'h8100);
    do_write(1'b0, 4'd15, 16'h0000);
    do_read("R6 collision low byte", 1'b0, 4'd15, 16'h0077);

    // R4: read issued with the bank-switching write uses the old bank
    wr_en = 1; wr_from_bus = 0; wr_addr = 4'd15; alu_wdata = 16'h8000; bus_wdata = 16'h0;
    rd_en = 1; rd_to_bus = 1; rd_addr = 4'd0;
    @(negedge clk);
    wr_en = 0;
    check("R4 switch visible next cycle", {15'd0, bank_sel}, 16'h1);
    @(negedge clk);
    rd_en = 0;
    check("R4 same-cycle read old bank", bus_rdata, 16'h1234);
    @(negedge clk);
    check("R4 next-cycle read new bank", bus_rdata, 16'h5A5A);
    do_write(1'b1, 4'd15, 16'h0000);

    // R8: read and write to the same register in one cycle
    rd_en = 1; rd_to_bus = 0; rd_addr = 4'd3;
    do_write(1'b0, 4'd3, 16'h1111);
    rd_en = 0;
    @(negedge clk);
    check("R8 read-before-write", alu_rdata, 16'h ABCD);
    do_read("R8 new value after", 1'b0, 4'd3, 16'h1111);

    // R3: write with wr_en low is ignored
    wr_en = 0; wr_from_bus = 1; wr_addr = 4'd0; bus_wdata = 16'hDEAD; alu_wdata = 16'hBEEF;
    @(negedge clk);
    do_read("R3 disabled write ignored", 1'b1, 4'd0, 16'h1234);

    // R9: disabled reads leave outputs alone
    rd_en = 0; rd_to_bus = 1; rd_addr = 4'd7;
    repeat (3) @(negedge clk);
    check("R9 bus data held", bus_rdata, 16'h1234);
    check("R9 alu data held", alu_rdata, 16'h1111);
    check("R9 no valid", {14'd0, alu_rvalid, bus_rvalid}, 16'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule